// File: doc/BRIEF.md
# Configurable Counter Channel

One channel of a multi-channel counter/timer. It watches a chosen input signal, detects edges of one chosen polarity, and steps a 16-bit count on each edge it accepts. A gating mode decides which edges are accepted. Accepted edges are taken only while the channel is armed. The count moves up or down, in plain binary or in four-bit decimal digits. When a step would leave the count at zero, the channel raises a terminal-count event and reloads instead. The reload value comes from an external load value, or alternately from that value and an internal hold register. Depending on the mode, the channel then keeps running or stops.

A 16-bit mode word sets the gating, the source, the edge polarity, the reload scheme, run-once or repeat, the number system, the direction and the output waveform. Single-cycle strobes arm, disarm, load and save the channel. The neighbour channels, the bus decoding and the frequency generation sit outside the block. The inputs arrive as plain vectors with one bit per channel. All inputs are sampled on the rising clock edge.

Top module: `cnt_chan`

## Requirements
- R1: Synchronous active-high reset sets the count to 0, clears the mode word and the hold register, disarms the channel, and drives tc_o=0, pin_o=0 and oe_o=1.
- R2: A source edge changes the count only while the channel is armed. arm_i arms the channel and disarm_i disarms it. When both strobes arrive in the same cycle, disarm_i wins.
- R3: The mode word has these fields: gating [15:13], edge polarity [12], source [11:8], bit 7 reserved, alternate reload [6], repeat [5], decimal [4], direction [3] and output style [2:0]. A mode write while the channel is armed is ignored.
- R4: Source codes pick the input that is counted. Code 0 is lower_tc_i. Codes 1 to 5 are src_i[0..4]. Codes 6 to 10 are gate_i[0..4]. Codes 11 to 15 are freq_i[0..4]. Bit 12 = 0 counts rising edges and bit 12 = 1 counts falling edges.
- R5: Gating codes qualify the counted edges. 000 means no gating. 001 accepts edges while lower_tc_i is high. 010 uses gate_i of the next channel (wrapping) at high level. 011 uses gate_i of the previous channel (wrapping) at high level. 100 uses this channel's own gate at high level, and 101 uses it at low level. 110 enables counting after a rising edge of the own gate while armed, and 111 after a falling edge; this enable clears whenever the channel is disarmed.
- R6: Bit 3 = 0 counts down and bit 3 = 1 counts up. Bit 4 = 1 counts in decimal digits: a digit wraps 9 to 0 going up and 0 to 9 going down, and passes a carry or borrow to the next digit. With bit 4 = 0 the count is plain binary.
- R7: A step whose result would be zero is a terminal count. The count takes the reload value instead, and tc_o goes high for exactly one cycle, one cycle after the edge. load_i copies load_val_i into the count and takes priority over a step.
- R8: With bit 6 = 0 every reload uses load_val_i. With bit 6 = 1 reloads alternate, hold register first and then load_val_i. A load_i restarts the alternation with the hold register.
- R9: With bit 5 = 1 the channel keeps counting until it is disarmed. With bit 5 = 0 it disarms itself after one full cycle: one terminal count without alternate reload, or two with it.
- R10: save_i copies the live count into the hold register without disturbing counting, and takes priority over hold_we_i, which writes hold_val_i.
- R11: Output style codes set the output pin. 000 holds pin_o low. 001 drives a one-cycle high pulse at terminal count. 010 toggles at each terminal count, starting low after any other style. 100 drives oe_o=0 with pin_o low. 101 drives a one-cycle low pulse. Codes 011, 110 and 111 hold pin_o low. The pin is registered, so it changes in the same cycle as tc_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we_i | input | 1 | Mode word write strobe |
| mode_i | input | 16 | Mode word value |
| load_val_i | input | W | Load register value |
| hold_we_i | input | 1 | Hold register write strobe |
| hold_val_i | input | W | Hold register write value |
| arm_i | input | 1 | Arm strobe |
| disarm_i | input | 1 | Disarm strobe |
| load_i | input | 1 | Load count from load_val_i |
| save_i | input | 1 | Copy count into hold register |
| src_i | input | NCH | Source pins of all channels |
| gate_i | input | NCH | Gate pins of all channels |
| freq_i | input | NCH | Internal frequency taps |
| lower_tc_i | input | 1 | Terminal count of the next lower channel |
| count_o | output | W | Live count |
| tc_o | output | 1 | Terminal-count pulse |
| pin_o | output | 1 | Output pin level |
| oe_o | output | 1 | Output pin drive enable |

## Verification
Most stimulus is single edges on one source at a time. Decrements, increments and decimal steps are told apart by choosing start values where the results differ: 0x0100 gives 0x0099 in decimal and 0x00FF in binary, and 0x0099 gives 0x0100 going up. Edges on sources that are not selected, and edges that arrive while the gate is closed, must leave the count unchanged. That shows the mux code and the gate polarity are used as intended. Reload sequences with different load and hold values, plus a save in between, separate hold reloads from load reloads. They also separate saved hold contents from written hold contents, and one-TC stops from two-TC stops.

// File: rtl/cnt_chan_pkg.sv
package cnt_chan_pkg;

  typedef struct packed {
    logic [2:0] gsel;
    logic       fall;
    logic [3:0] csel;
    logic       rsv;
    logic       alt;
    logic       rep;
    logic       bcd;
    logic       up;
    logic [2:0] wave;
  } cmode_t;

  localparam logic [2:0] G_NONE  = 3'd0;
  localparam logic [2:0] G_LOWTC = 3'd1;
  localparam logic [2:0] G_NEXT  = 3'd2;
  localparam logic [2:0] G_PREV  = 3'd3;
  localparam logic [2:0] G_HI    = 3'd4;
  localparam logic [2:0] G_LO    = 3'd5;
  localparam logic [2:0] G_RISE  = 3'd6;
  localparam logic [2:0] G_FALL  = 3'd7;

  localparam logic [2:0] WV_LOW    = 3'd0;
  localparam logic [2:0] WV_PULSE  = 3'd1;
  localparam logic [2:0] WV_TOG    = 3'd2;
  localparam logic [2:0] WV_HIZ    = 3'd4;
  localparam logic [2:0] WV_NPULSE = 3'd5;

endpackage

// File: rtl/cnt_trig.sv
module cnt_trig
  import cnt_chan_pkg::*;
#(
  parameter int NCH = 5,
  parameter int CH  = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           armed_i,
  input  logic [2:0]     gsel_i,
  input  logic           fall_i,
  input  logic [3:0]     csel_i,
  input  logic [NCH-1:0] src_i,
  input  logic [NCH-1:0] gate_i,
  input  logic [NCH-1:0] freq_i,
  input  logic           lower_tc_i,
  output logic           fire_o
);
  localparam int NSRC = 3 * NCH + 1;
  localparam int GNX  = (CH + 1) % NCH;
  localparam int GPV  = (CH + NCH - 1) % NCH;

  logic [NSRC-1:0] cand;
  logic            picked, picked_q;
  logic            own, own_q, gflag_q, gedge;
  logic            gate_ok, edge_hit;

  assign cand = {freq_i, gate_i, src_i, lower_tc_i};
  assign own  = gate_i[CH];

  always_comb begin
    picked = 1'b0;
    for (int k = 0; k < NSRC; k++)
      if (csel_i == 4'(k)) picked = cand[k];
  end

  assign gedge = (gsel_i == G_RISE) ? (own & ~own_q) : (~own & own_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      picked_q <= 1'b0;
      own_q    <= 1'b0;
      gflag_q  <= 1'b0;
    end else begin
      picked_q <= picked;
      own_q    <= own;
      if (!armed_i)
        gflag_q <= 1'b0;
      else if (gsel_i[2:1] == 2'b11 && gedge)
        gflag_q <= 1'b1;
    end
  end

  always_comb begin
    case (gsel_i)
      G_NONE:  gate_ok = 1'b1;
      G_LOWTC: gate_ok = lower_tc_i;
      G_NEXT:  gate_ok = gate_i[GNX];
      G_PREV:  gate_ok = gate_i[GPV];
      G_HI:    gate_ok = own;
      G_LO:    gate_ok = ~own;
      default: gate_ok = gflag_q;
    endcase
  end

  assign edge_hit = fall_i ? (picked_q & ~picked) : (~picked_q & picked);
  assign fire_o   = armed_i & gate_ok & edge_hit;

  // R5
  edge_gate_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (gsel_i[2:1] == 2'b11 && !armed_i) |=> !gflag_q);

endmodule

// File: rtl/cnt_step.sv
module cnt_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] cur_i,
  input  logic         up_i,
  input  logic         bcd_i,
  output logic [W-1:0] nxt_o,
  output logic         wrap_o
);
  localparam int ND = W / 4;

  logic [W-1:0] bin_v, dec_v;
  logic [ND:0]  cy;

  assign cy[0] = 1'b1;
  assign bin_v = up_i ? cur_i + 1'b1 : cur_i - 1'b1;

  for (genvar d = 0; d < ND; d++) begin : g_dig
    logic [3:0] dg, rs;
    logic       co;
    assign dg = cur_i[4*d +: 4];
    always_comb begin
      rs = dg;
      co = 1'b0;
      if (cy[d]) begin
        if (up_i) begin
          if (dg >= 4'd9) begin
            rs = 4'd0;
            co = 1'b1;
          end else begin
            rs = dg + 4'd1;
          end
        end else begin
          if (dg == 4'd0) begin
            rs = 4'd9;
            co = 1'b1;
          end else if (dg > 4'd9) begin
            rs = 4'd9;
          end else begin
            rs = dg - 4'd1;
          end
        end
      end
    end
    assign dec_v[4*d +: 4] = rs;
    assign cy[d+1] = co;
  end

  assign nxt_o  = bcd_i ? dec_v : bin_v;
  assign wrap_o = (bcd_i && up_i) ? cy[ND] : (nxt_o == '0);

endmodule

// File: rtl/cnt_wave.sv
module cnt_wave
  import cnt_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] wave_i,
  input  logic       tc_ev_i,
  output logic       tc_o,
  output logic       pin_o,
  output logic       oe_o
);
  logic tog_q, tog_n;

  assign tog_n = (wave_i == WV_TOG) ? (tog_q ^ tc_ev_i) : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_o  <= 1'b0;
      tog_q <= 1'b0;
      pin_o <= 1'b0;
      oe_o  <= 1'b1;
    end else begin
      tc_o  <= tc_ev_i;
      tog_q <= tog_n;
      oe_o  <= (wave_i != WV_HIZ);
      case (wave_i)
        WV_PULSE:  pin_o <= tc_ev_i;
        WV_TOG:    pin_o <= tog_n;
        WV_NPULSE: pin_o <= ~tc_ev_i;
        default:   pin_o <= 1'b0;
      endcase
    end
  end

  // R7
  tc_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tc_o |=> !tc_o);

  // R11
  hiz_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_o |-> !pin_o);

endmodule

// File: rtl/cnt_chan.sv
module cnt_chan
  import cnt_chan_pkg::*;
#(
  parameter int W   = 16,
  parameter int NCH = 5,
  parameter int CH  = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode_we_i,
  input  logic [15:0]    mode_i,
  input  logic [W-1:0]   load_val_i,
  input  logic           hold_we_i,
  input  logic [W-1:0]   hold_val_i,
  input  logic           arm_i,
  input  logic           disarm_i,
  input  logic           load_i,
  input  logic           save_i,
  input  logic [NCH-1:0] src_i,
  input  logic [NCH-1:0] gate_i,
  input  logic [NCH-1:0] freq_i,
  input  logic           lower_tc_i,
  output logic [W-1:0]   count_o,
  output logic           tc_o,
  output logic           pin_o,
  output logic           oe_o
);
  cmode_t       mode_q;
  logic [W-1:0] count_q, hold_q, nxt, reload;
  logic         armed_q, alt_ph_q;
  logic         fire, wrap, tc_ev, stop;

  cnt_trig #(.NCH(NCH), .CH(CH)) u_trig (
    .clk(clk), .rst(rst), .armed_i(armed_q),
    .gsel_i(mode_q.gsel), .fall_i(mode_q.fall), .csel_i(mode_q.csel),
    .src_i(src_i), .gate_i(gate_i), .freq_i(freq_i),
    .lower_tc_i(lower_tc_i), .fire_o(fire)
  );

  cnt_step #(.W(W)) u_step (
    .cur_i(count_q), .up_i(mode_q.up), .bcd_i(mode_q.bcd),
    .nxt_o(nxt), .wrap_o(wrap)
  );

  assign tc_ev  = fire & wrap & ~load_i;
  assign reload = (mode_q.alt && !alt_ph_q) ? hold_q : load_val_i;
  assign stop   = ~mode_q.rep & (~mode_q.alt | alt_ph_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      count_q  <= '0;
      hold_q   <= '0;
      armed_q  <= 1'b0;
      alt_ph_q <= 1'b0;
    end else begin
      if (mode_we_i && !armed_q) mode_q <= cmode_t'(mode_i);

      if (save_i)         hold_q <= count_q;
      else if (hold_we_i) hold_q <= hold_val_i;

      if (load_i) begin
        count_q  <= load_val_i;
        alt_ph_q <= 1'b0;
      end else if (fire) begin
        if (wrap) begin
          count_q <= reload;
          if (mode_q.alt) alt_ph_q <= ~alt_ph_q;
        end else begin
          count_q <= nxt;
        end
      end

      if (disarm_i)          armed_q <= 1'b0;
      else if (tc_ev && stop) armed_q <= 1'b0;
      else if (arm_i)        armed_q <= 1'b1;
    end
  end

  cnt_wave u_wave (
    .clk(clk), .rst(rst), .wave_i(mode_q.wave), .tc_ev_i(tc_ev),
    .tc_o(tc_o), .pin_o(pin_o), .oe_o(oe_o)
  );

  assign count_o = count_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && !load_i) |=> (count_o == $past(count_o)));

  // R3
  mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && mode_we_i) |=> (mode_q == $past(mode_q)));

  // R9
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (tc_ev && !mode_q.rep && !mode_q.alt) |=> !armed_q);

  // R10
  save_copy_chk: assert property (@(posedge clk) disable iff (rst)
    save_i |=> (hold_q == $past(count_q)));

endmodule

// File: tb/cnt_chan_test.sv
module cnt_chan_test;
  localparam int W = 16;
  localparam int NCH = 5;

  typedef struct {
    string       tag;
    logic [31:0] v;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_we_i = 0, hold_we_i = 0, arm_i = 0, disarm_i = 0, load_i = 0, save_i = 0;
  logic [15:0] mode_i = '0;
  logic [W-1:0] load_val_i = '0, hold_val_i = '0;
  logic [NCH-1:0] src_i = '0, gate_i = '0, freq_i = '0;
  logic lower_tc_i = 1'b0;
  logic [W-1:0] count_o;
  logic tc_o, pin_o, oe_o;

  int runs = 0, fails = 0;
  exp_t sb[$];

  always #5 clk = ~clk;

  cnt_chan #(.W(W), .NCH(NCH), .CH(0)) uut (
    .clk(clk), .rst(rst), .mode_we_i(mode_we_i), .mode_i(mode_i),
    .load_val_i(load_val_i), .hold_we_i(hold_we_i), .hold_val_i(hold_val_i),
    .arm_i(arm_i), .disarm_i(disarm_i), .load_i(load_i), .save_i(save_i),
    .src_i(src_i), .gate_i(gate_i), .freq_i(freq_i), .lower_tc_i(lower_tc_i),
    .count_o(count_o), .tc_o(tc_o), .pin_o(pin_o), .oe_o(oe_o)
  );

  function automatic logic [15:0] mk(logic [2:0] g, logic f, logic [3:0] s,
                                     logic alt, logic rep, logic bcd, logic up, logic [2:0] wv);
    return {g, f, s, 1'b0, alt, rep, bcd, up, wv};
  endfunction

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // driver side: expected item
  task automatic expect_item(string tag, logic [31:0] v);
    exp_t e;
    e.tag = tag;
    e.v = v;
    sb.push_back(e);
  endtask

  // monitor side: pop and compare with what the design shows
  task automatic observe(logic [31:0] act);
    exp_t e;
    e = sb.pop_front();
    runs++;
    if (act !== e.v) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", e.tag, act, e.v);
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] ex);
    expect_item(tag, ex);
    observe(act);
  endtask

  task automatic wr_mode(logic [15:0] m);
    mode_i = m; mode_we_i = 1; tick(); mode_we_i = 0;
  endtask
  task automatic do_load(logic [W-1:0] v);
    load_val_i = v; load_i = 1; tick(); load_i = 0;
  endtask
  task automatic do_arm();
    arm_i = 1; tick(); arm_i = 0;
  endtask
  task automatic do_disarm();
    disarm_i = 1; tick(); disarm_i = 0;
  endtask
  task automatic wr_hold(logic [W-1:0] v);
    hold_val_i = v; hold_we_i = 1; tick(); hold_we_i = 0;
  endtask
  task automatic drive(int kind, int idx, logic v);
    case (kind)
      0: src_i[idx] = v;
      1: gate_i[idx] = v;
      2: freq_i[idx] = v;
      default: lower_tc_i = v;
    endcase
    tick();
  endtask
  task automatic pulse(int kind, int idx);
    drive(kind, idx, 1'b1);
    drive(kind, idx, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    tick(3);
    rst = 0;
    tick();
    // R1 reset state
    chk("R1 count", count_o, 0);
    chk("R1 tc", tc_o, 0);
    chk("R1 pin", pin_o, 0);
    chk("R1 oe", oe_o, 1);

    // R2/R7/R11: down binary repeat, toggle output, source code 1
    wr_mode(mk(3'd0, 0, 4'd1, 0, 1, 0, 0, 3'd2));
    do_load(16'd3);
    chk("R7 load", count_o, 3);
    pulse(0, 0);
    chk("R2 disarmed", count_o, 3);
    do_arm();
    pulse(0, 0); chk("R6 down", count_o, 2);
    pulse(0, 0); chk("R6 down", count_o, 1);
    drive(0, 0, 1);
    chk("R7 reload", count_o, 3);
    chk("R7 tc high", tc_o, 1);
    chk("R11 toggle", pin_o, 1);
    drive(0, 0, 0);
    chk("R7 tc one cycle", tc_o, 0);
    chk("R11 toggle held", pin_o, 1);

    // R3 mode write ignored while armed
    wr_mode(mk(3'd0, 0, 4'd1, 0, 1, 0, 1, 3'd0));
    pulse(0, 0); chk("R3 locked", count_o, 2);
    do_disarm();
    wr_mode(mk(3'd0, 0, 4'd1, 0, 1, 0, 1, 3'd0));
    do_arm();
    pulse(0, 0); chk("R6 up", count_o, 3);

    // R6 decimal up / down, R7 reload on up wrap
    do_disarm();
    wr_mode(mk(3'd0, 0, 4'd1, 0, 1, 1, 1, 3'd0));
    do_load(16'h0099);
    do_arm();
    pulse(0, 0); chk("R6 bcd up", count_o, 16'h0100);
    do_disarm();
    do_load(16'h9999);
    load_val_i = 16'h0042;
    do_arm();
    drive(0, 0, 1);
    chk("R7 up wrap", count_o, 16'h0042);
    chk("R7 up tc", tc_o, 1);
    drive(0, 0, 0);
    do_disarm();
    wr_mode(mk(3'd0, 0, 4'd1, 0, 1, 1, 0, 3'd0));
    do_load(16'h0100);
    do_arm();
    pulse(0, 0); chk("R6 bcd down", count_o, 16'h0099);

    // R4 falling edge
    do_disarm();
    wr_mode(mk(3'd0, 1, 4'd1, 0, 1, 0, 0, 3'd0));
    do_load(16'd10);
    do_arm();
    drive(0, 0, 1); chk("R4 rise ignored", count_o, 10);
    drive(0, 0, 0); chk("R4 fall counted", count_o, 9);

    // R4 source codes
    do_disarm();
    wr_mode(mk(3'd0, 0, 4'd0, 0, 1, 0, 0, 3'd0));
    do_load(16'd10);
    do_arm();
    pulse(3, 0); chk("R4 lower tc", count_o, 9);
    pulse(0, 0); chk("R4 unselected", count_o, 9);
    do_disarm();
    wr_mode(mk(3'd0, 0, 4'd7, 0, 1, 0, 0, 3'd0));
    do_arm();
    pulse(1, 1); chk("R4 gate src", count_o, 8);
    pulse(1, 0); chk("R4 other gate", count_o, 8);
    do_disarm();
    wr_mode(mk(3'd0, 0, 4'd11, 0, 1, 0, 0, 3'd0));
    do_arm();
    pulse(2, 0); chk("R4 freq", count_o, 7);

    // R5 gating
    do_disarm();
    wr_mode(mk(3'd4, 0, 4'd1, 0, 1, 0, 0, 3'd0));
    do_load(16'd5);
    do_arm();
    pulse(0, 0); chk("R5 own gate low", count_o, 5);
    drive(1, 0, 1);
    pulse(0, 0); chk("R5 own gate high", count_o, 4);
    do_disarm();
    drive(1, 0, 0);
    wr_mode(mk(3'd3, 0, 4'd1, 0, 1, 0, 0, 3'd0));
    do_arm();
    pulse(0, 0); chk("R5 prev gate low", count_o, 4);
    drive(1, 4, 1);
    pulse(0, 0); chk("R5 prev gate wrap", count_o, 3);
    do_disarm();
    drive(1, 4, 0);
    wr_mode(mk(3'd6, 0, 4'd1, 0, 1, 0, 0, 3'd0));
    do_arm();
    pulse(0, 0); chk("R5 before gate edge", count_o, 3);
    drive(1, 0, 1);
    pulse(0, 0); chk("R5 after gate edge", count_o, 2);
    do_disarm();
    drive(1, 0, 0);

    // R2 disarm wins over arm
    arm_i = 1; disarm_i = 1; tick(); arm_i = 0; disarm_i = 0;
    pulse(0, 0); chk("R2 disarm priority", count_o, 2);

    // R8 alternate reload, R10 save
    wr_hold(16'd2);
    wr_mode(mk(3'd0, 0, 4'd1, 1, 1, 0, 0, 3'd0));
    do_load(16'd3);
    do_arm();
    pulse(0, 0); pulse(0, 0);
    drive(0, 0, 1); chk("R8 hold reload", count_o, 2);
    chk("R8 tc", tc_o, 1);
    drive(0, 0, 0);
    pulse(0, 0);
    pulse(0, 0); chk("R8 load reload", count_o, 3);
    save_i = 1; hold_we_i = 1; hold_val_i = 16'd7; tick(); save_i = 0; hold_we_i = 0;
    pulse(0, 0); pulse(0, 0);
    pulse(0, 0); chk("R10 saved hold", count_o, 3);

    // R9 one-shot, R11 pulse style
    do_disarm();
    wr_mode(mk(3'd0, 0, 4'd1, 0, 0, 0, 0, 3'd1));
    do_load(16'd2);
    do_arm();
    pulse(0, 0);
    drive(0, 0, 1);
    chk("R9 oneshot reload", count_o, 2);
    chk("R11 pulse high", pin_o, 1);
    drive(0, 0, 0);
    chk("R11 pulse ends", pin_o, 0);
    pulse(0, 0); chk("R9 stopped", count_o, 2);
    wr_hold(16'd1);
    wr_mode(mk(3'd0, 0, 4'd1, 1, 0, 0, 0, 3'd0));
    do_load(16'd2);
    do_arm();
    pulse(0, 0);
    pulse(0, 0); chk("R9 first tc runs on", count_o, 1);
    pulse(0, 0); chk("R9 second tc", count_o, 2);
    pulse(0, 0); chk("R9 stopped after two", count_o, 2);

    // R11 remaining styles
    wr_mode(mk(3'd0, 0, 4'd1, 0, 1, 0, 0, 3'd5));
    do_load(16'd1);
    do_arm();
    tick();
    chk("R11 low pulse idle", pin_o, 1);
    drive(0, 0, 1);
    chk("R11 low pulse", pin_o, 0);
    drive(0, 0, 0);
    chk("R11 low pulse ends", pin_o, 1);
    do_disarm();
    wr_mode(mk(3'd0, 0, 4'd1, 0, 1, 0, 0, 3'd4));
    tick(2);
    chk("R11 hiz oe", oe_o, 0);
    chk("R11 hiz pin", pin_o, 0);
    wr_mode(mk(3'd0, 0, 4'd1, 0, 1, 0, 0, 3'd3));
    do_arm();
    drive(0, 0, 1);
    chk("R11 illegal tc", tc_o, 1);
    chk("R11 illegal pin", pin_o, 0);
    chk("R11 illegal oe", oe_o, 1);
    drive(0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule